// File: doc/BRIEF.md
# Wait-State SRAM and Register Access Sequencer

This block sits between two requesters and two targets. A local processor port and a bus slave port each issue single-word reads and writes. Each access goes either to an external asynchronous SRAM or to a small internal register file. The top address bit picks the target. The block drives the SRAM strobes from registers, counts wait states, and returns read data with a one-cycle ready pulse.

A configuration bit sits in bit 0 of register 0 and sets the SRAM access length. It comes out of reset as 1, which gives one wait state. The local processor sees register accesses with exactly the same timing as SRAM accesses. Register accesses from the slave port always run with no wait states.

A slave-port read that misses in SRAM space starts a background fill of the four words that follow the read address. The fill goes into a small prefetch buffer. Later slave reads that land on a filled entry are answered from the buffer without touching the SRAM. Any SRAM write that falls inside the buffer window drops all buffered words. When both ports request in the same cycle, the local port is served first. A background fill gives way to either port between word accesses.

Top module: `sram_ws_ctrl`

## Requirements
- R1: After reset, register 0 reads as 1 and the SRAM strobes and both ready outputs are low. With the wait bit at 1, an SRAM access holds chip enable for two cycles, and ready arrives 3 clock edges after valid is first sampled.
- R2: With the wait bit at 0, an SRAM access holds chip enable for one cycle, and ready arrives 2 edges after valid is sampled.
- R3: Local-port register reads and writes take the same number of cycles as a local-port SRAM access under the current wait bit (3 edges with bit 1, 2 edges with bit 0).
- R4: Slave-port register accesses always complete 2 edges after valid is sampled, whatever the wait bit says.
- R5: A slave-port SRAM read at address A that misses the buffer is followed by SRAM reads of A+1, A+2, A+3 and A+4, in that order, wrapping inside the SRAM address space.
- R6: A slave-port SRAM read whose word is valid in the prefetch buffer returns that word 1 edge after valid is sampled, and it starts no SRAM cycle.
- R7: An SRAM write from either port to an address inside the buffer window clears every buffered word. The next slave read of that address goes to the SRAM and returns the newly written data.
- R8: When both ports present valid in the same idle cycle, the local port is granted first.
- R9: A pending prefetch fill is interrupted between word accesses by a local-port request. That request is served before the remaining fill words, and the fill then completes.
- R10: Each ready output is high for exactly one cycle per transaction.
- R11: During an SRAM write, chip enable, write enable and data-bus drive are high and output enable is low. During an SRAM read, output enable is high and both write enable and data-bus drive are low.
- R12: An address with its top bit set selects register (low bits index it). Such accesses start no SRAM cycle and leave SRAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_valid | input | 1 | Local port request valid, held until ready |
| lp_write | input | 1 | Local port: 1 write, 0 read |
| lp_addr | input | AW | Local port word address; top bit selects registers |
| lp_wdata | input | DW | Local port write data |
| lp_ready | output | 1 | Local port one-cycle completion pulse |
| lp_rdata | output | DW | Local port read data, valid with ready |
| sp_valid | input | 1 | Slave port request valid, held until ready |
| sp_write | input | 1 | Slave port: 1 write, 0 read |
| sp_addr | input | AW | Slave port word address; top bit selects registers |
| sp_wdata | input | DW | Slave port write data |
| sp_ready | output | 1 | Slave port one-cycle completion pulse |
| sp_rdata | output | DW | Slave port read data, valid with ready |
| sram_addr | output | AW-1 | Registered SRAM word address |
| sram_ce | output | 1 | SRAM chip enable |
| sram_oe | output | 1 | SRAM output enable |
| sram_we | output | 1 | SRAM write enable |
| sram_dout | output | DW | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Drive enable for the SRAM data bus |
| sram_din | input | DW | Data returned by the SRAM |

## Verification
The same read is issued from both ports, to both targets, under both settings of the wait bit. Comparing the measured latencies separates local-port register timing, which follows the bit, from slave-port register timing, which does not. A slave miss followed by reads of the next words separates buffer hits (1-edge latency, no SRAM cycle) from misses. A write inside the window, sent from each port in turn, shows whether stale words are dropped. Simultaneous requests, and a local request injected during a fill, expose the grant order and the sequence of SRAM addresses.

// File: rtl/sramctl_pkg.sv
package sramctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        OWN_LP = 2'd0,
        OWN_SP = 2'd1,
        OWN_PF = 2'd2
    } owner_e;

    // fixed by behaviour: a slave miss fills this many following words
    localparam int PF_WORDS = 4;

    // requester index in the arbiter (lower index wins)
    localparam int REQ_LP = 0;
    localparam int REQ_SP = 1;
    localparam int REQ_PF = 2;
    localparam int NREQ   = 3;

endpackage

// File: rtl/sramctl_arb.sv
module sramctl_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // fixed priority: index 0 highest
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sramctl_regfile.sv
module sramctl_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] idx,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    output logic                    wait_bit
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= (i == 0) ? DW'(1) : '0;
            end
        end else if (we) begin
            regs[idx] <= wdata;
        end
    end

    assign rdata    = regs[idx];
    assign wait_bit = regs[0][0];
endmodule

// File: rtl/sramctl_pfbuf.sv
module sramctl_pfbuf #(
    parameter int SAW   = 9,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_en,
    input  logic [SAW-1:0]           load_base,
    input  logic                     fill_en,
    input  logic [$clog2(DEPTH)-1:0] fill_idx,
    input  logic [DW-1:0]            fill_data,
    input  logic [SAW-1:0]           look_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data,
    input  logic                     wr_en,
    input  logic [SAW-1:0]           wr_addr,
    output logic                     covered,
    output logic [SAW-1:0]           base
);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0] valid;
    logic [DW-1:0]    words [DEPTH];
    logic [SAW-1:0]   look_off, wr_off;

    assign look_off = look_addr - base;
    assign wr_off   = wr_addr - base;
    assign hit      = (look_off < SAW'(DEPTH)) && valid[look_off[IW-1:0]];
    assign hit_data = words[look_off[IW-1:0]];
    assign covered  = wr_en && (wr_off < SAW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            base  <= '0;
        end else if (load_en) begin
            valid <= '0;
            base  <= load_base;
        end else if (covered) begin
            valid <= '0;
        end else if (fill_en) begin
            valid[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) words[fill_idx] <= fill_data;
    end

    // R7: a write inside the window leaves nothing valid
    a_r7_window_cleared: assert property (@(posedge clk) disable iff (rst)
        (covered && !load_en) |=> (valid == '0));
endmodule

// File: rtl/sram_ws_ctrl.sv
module sram_ws_ctrl #(
    parameter int AW   = 10,
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lp_valid,
    input  logic          lp_write,
    input  logic [AW-1:0] lp_addr,
    input  logic [DW-1:0] lp_wdata,
    output logic          lp_ready,
    output logic [DW-1:0] lp_rdata,
    input  logic          sp_valid,
    input  logic          sp_write,
    input  logic [AW-1:0] sp_addr,
    input  logic [DW-1:0] sp_wdata,
    output logic          sp_ready,
    output logic [DW-1:0] sp_rdata,
    output logic [AW-2:0] sram_addr,
    output logic          sram_ce,
    output logic          sram_oe,
    output logic          sram_we,
    output logic [DW-1:0] sram_dout,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_din
);
    import sramctl_pkg::*;

    localparam int SAW = AW - 1;
    localparam int RIW = $clog2(NREG);
    localparam int PIW = $clog2(PF_WORDS);

    seq_state_e     state;
    owner_e         owner;
    logic           cnt;
    logic           q_wr, q_reg;
    logic [RIW-1:0] q_ridx;
    logic           pf_active;
    logic [PIW-1:0] pf_idx;

    logic [NREQ-1:0] req, gnt;
    logic [AW-1:0]   sel_addr;
    logic [DW-1:0]   sel_wdata;
    logic            sel_wr, sel_reg, port_gnt;
    logic            wait_bit, sp_sram_rd, sp_hit, buf_hit, covered, load_en;
    logic            fill_en, rf_we, finishing;
    logic [DW-1:0]   hit_data, rf_rdata;
    logic [SAW-1:0]  pf_base, pf_addr;

    assign req = (state == ST_IDLE) ? {pf_active, sp_valid, lp_valid} : '0;

    sramctl_arb #(.N(NREQ)) u_arb (.req(req), .gnt(gnt));

    assign port_gnt  = gnt[REQ_LP] | gnt[REQ_SP];
    assign sel_addr  = gnt[REQ_LP] ? lp_addr  : sp_addr;
    assign sel_wdata = gnt[REQ_LP] ? lp_wdata : sp_wdata;
    assign sel_wr    = gnt[REQ_LP] ? lp_write : sp_write;
    assign sel_reg   = sel_addr[AW-1];

    assign sp_sram_rd = gnt[REQ_SP] && !sp_write && !sp_addr[AW-1];
    assign sp_hit     = sp_sram_rd && buf_hit;
    assign load_en    = sp_sram_rd && !buf_hit;
    assign finishing  = (state == ST_ACC) && !cnt;
    assign fill_en    = finishing && (owner == OWN_PF);
    assign rf_we      = finishing && (owner != OWN_PF) && q_wr && q_reg;
    assign pf_addr    = pf_base + SAW'(pf_idx);

    sramctl_regfile #(.NREG(NREG), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .we(rf_we), .idx(q_ridx), .wdata(sram_dout),
        .rdata(rf_rdata), .wait_bit(wait_bit)
    );

    sramctl_pfbuf #(.SAW(SAW), .DW(DW), .DEPTH(PF_WORDS)) u_pfbuf (
        .clk(clk), .rst(rst),
        .load_en(load_en), .load_base(sp_addr[SAW-1:0] + SAW'(1)),
        .fill_en(fill_en), .fill_idx(pf_idx), .fill_data(sram_din),
        .look_addr(sp_addr[SAW-1:0]), .hit(buf_hit), .hit_data(hit_data),
        .wr_en(port_gnt && sel_wr && !sel_reg), .wr_addr(sel_addr[SAW-1:0]),
        .covered(covered), .base(pf_base)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            owner      <= OWN_LP;
            cnt        <= 1'b0;
            q_wr       <= 1'b0;
            q_reg      <= 1'b0;
            q_ridx     <= '0;
            pf_active  <= 1'b0;
            pf_idx     <= '0;
            lp_ready   <= 1'b0;
            sp_ready   <= 1'b0;
            lp_rdata   <= '0;
            sp_rdata   <= '0;
            sram_addr  <= '0;
            sram_ce    <= 1'b0;
            sram_oe    <= 1'b0;
            sram_we    <= 1'b0;
            sram_dq_oe <= 1'b0;
            sram_dout  <= '0;
        end else begin
            lp_ready <= 1'b0;
            sp_ready <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (port_gnt) begin
                        owner     <= gnt[REQ_LP] ? OWN_LP : OWN_SP;
                        q_wr      <= sel_wr;
                        q_reg     <= sel_reg;
                        q_ridx    <= sel_addr[RIW-1:0];
                        sram_dout <= sel_wdata;
                        if (sp_hit) begin
                            sp_rdata <= hit_data;
                            sp_ready <= 1'b1;
                            state    <= ST_RESP;
                        end else begin
                            state <= ST_ACC;
                            cnt   <= (gnt[REQ_SP] && sel_reg) ? 1'b0 : wait_bit;
                            if (!sel_reg) begin
                                sram_addr  <= sel_addr[SAW-1:0];
                                sram_ce    <= 1'b1;
                                sram_oe    <= !sel_wr;
                                sram_we    <= sel_wr;
                                sram_dq_oe <= sel_wr;
                            end
                        end
                        if (load_en) begin
                            pf_active <= 1'b1;
                            pf_idx    <= '0;
                        end
                        if (covered) pf_active <= 1'b0;
                    end else if (gnt[REQ_PF]) begin
                        owner     <= OWN_PF;
                        q_wr      <= 1'b0;
                        q_reg     <= 1'b0;
                        cnt       <= wait_bit;
                        state     <= ST_ACC;
                        sram_addr <= pf_addr;
                        sram_ce   <= 1'b1;
                        sram_oe   <= 1'b1;
                    end
                end
                ST_ACC: begin
                    if (cnt) begin
                        cnt <= 1'b0;
                    end else begin
                        sram_ce    <= 1'b0;
                        sram_oe    <= 1'b0;
                        sram_we    <= 1'b0;
                        sram_dq_oe <= 1'b0;
                        if (owner == OWN_PF) begin
                            pf_idx <= pf_idx + PIW'(1);
                            if (pf_idx == PIW'(PF_WORDS - 1)) pf_active <= 1'b0;
                            state <= ST_IDLE;
                        end else begin
                            if (owner == OWN_LP) begin
                                lp_rdata <= q_reg ? rf_rdata : sram_din;
                                lp_ready <= 1'b1;
                            end else begin
                                sp_rdata <= q_reg ? rf_rdata : sram_din;
                                sp_ready <= 1'b1;
                            end
                            state <= ST_RESP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r10_lp_single: assert property (@(posedge clk) disable iff (rst)
        lp_ready |=> !lp_ready);
    a_r10_sp_single: assert property (@(posedge clk) disable iff (rst)
        sp_ready |=> !sp_ready);
    a_r11_write_strobes: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> (sram_ce && sram_dq_oe && !sram_oe));
    a_r11_read_strobes: assert property (@(posedge clk) disable iff (rst)
        sram_oe |-> (sram_ce && !sram_we && !sram_dq_oe));
    a_r1_two_cycle: assert property (@(posedge clk) disable iff (rst)
        ($rose(sram_ce) && wait_bit) |=> sram_ce);
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ($rose(sram_ce) && !wait_bit) |=> !sram_ce);
    a_r6_hit_no_sram: assert property (@(posedge clk) disable iff (rst)
        sp_hit |=> (sp_ready && !sram_ce));
    a_r8_local_first: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && lp_valid && sp_valid) |=> (owner == OWN_LP));
    a_r4_slave_reg_fast: assert property (@(posedge clk) disable iff (rst)
        (gnt[REQ_SP] && sp_addr[AW-1]) |-> ##2 sp_ready);
    a_r12_reg_no_sram: assert property (@(posedge clk) disable iff (rst)
        (port_gnt && sel_reg) |=> !sram_ce);
    a_r8_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
endmodule

// File: tb/sram_ws_ctrl_tb.sv
module sram_ws_ctrl_tb;
    localparam int AW  = 10;
    localparam int DW  = 16;
    localparam int SW  = 1 << (AW - 1);
    localparam logic [AW-1:0] REGB = AW'(1) << (AW - 1);

    logic          clk = 1'b0, rst = 1'b1;
    logic          lp_valid = 0, lp_write = 0, sp_valid = 0, sp_write = 0;
    logic [AW-1:0] lp_addr = '0, sp_addr = '0;
    logic [DW-1:0] lp_wdata = '0, sp_wdata = '0;
    logic          lp_ready, sp_ready, sram_ce, sram_oe, sram_we, sram_dq_oe;
    logic [DW-1:0] lp_rdata, sp_rdata, sram_dout, sram_din;
    logic [AW-2:0] sram_addr;

    logic [DW-1:0] mem [SW];
    int checks = 0, errors = 0;
    int log_a [256];
    int log_n = 0;
    logic ce_prev = 0, lpr_prev = 0, spr_prev = 0;
    int strobe_bad = 0, pulse_bad = 0, writes_seen = 0;

    always #4 clk = ~clk;

    sram_ws_ctrl #(.AW(AW), .DW(DW), .NREG(8)) u_dut (.*);

    assign sram_din = mem[sram_addr];
    always @(posedge clk) if (sram_ce && sram_we) mem[sram_addr] <= sram_dout;

    always @(negedge clk) begin
        if (!rst) begin
            if (sram_ce && !ce_prev && log_n < 256) begin
                log_a[log_n] = int'(sram_addr);
                log_n++;
            end
            if (sram_we && (!sram_ce || sram_oe || !sram_dq_oe)) strobe_bad++;
            if (sram_oe && (!sram_ce || sram_we || sram_dq_oe)) strobe_bad++;
            if (sram_we) writes_seen++;
            if ((lp_ready && lpr_prev) || (sp_ready && spr_prev)) pulse_bad++;
        end
        ce_prev  = sram_ce;
        lpr_prev = lp_ready;
        spr_prev = sp_ready;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic xfer(input bit sp, input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                        output int cyc);
        bit got = 0;
        @(negedge clk);
        if (sp) begin sp_valid = 1; sp_write = wr; sp_addr = a; sp_wdata = wd; end
        else    begin lp_valid = 1; lp_write = wr; lp_addr = a; lp_wdata = wd; end
        cyc = 0;
        while (!got && cyc < 100) begin
            @(posedge clk); #1;
            cyc++;
            got = sp ? sp_ready : lp_ready;
        end
        rd = sp ? sp_rdata : lp_rdata;
        @(negedge clk);
        sp_valid = 0; lp_valid = 0;
        if (!got) check("handshake timeout", 0, 1);
    endtask

    function automatic int find_pos(input int a);
        for (int i = 0; i < log_n; i++) if (log_a[i] == a) return i;
        return -1;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d; int c;
        check("R1 reset ce", int'(sram_ce), 0);
        check("R1 reset lp_ready", int'(lp_ready), 0);
        check("R1 reset sp_ready", int'(sp_ready), 0);
        xfer(1, 0, REGB, '0, d, c);
        check("R1 wait bit resets to 1", int'(d), 1);
    endtask

    task automatic t_wait_one();
        logic [DW-1:0] d; int c;
        xfer(0, 0, AW'(5), '0, d, c);
        check("R1 lp sram read latency", c, 3);
        check("R1 lp sram read data", int'(d), int'(mem[5]));
        xfer(0, 1, AW'(20), 16'hBEEF, d, c);
        check("R11 lp sram write latency", c, 3);
        check("R11 lp sram write stored", int'(mem[20]), 16'hBEEF);
        xfer(0, 1, REGB | AW'(3), 16'h1234, d, c);
        check("R3 lp reg write latency wait1", c, 3);
        xfer(0, 0, REGB | AW'(3), '0, d, c);
        check("R3 lp reg read latency wait1", c, 3);
        check("R3 lp reg read data", int'(d), 16'h1234);
        xfer(1, 0, REGB | AW'(3), '0, d, c);
        check("R4 sp reg read latency wait1", c, 2);
        check("R4 sp reg read data", int'(d), 16'h1234);
    endtask

    task automatic t_wait_zero();
        logic [DW-1:0] d; int c;
        xfer(0, 1, REGB, '0, d, c);
        check("R3 cfg write latency", c, 3);
        xfer(0, 0, AW'(7), '0, d, c);
        check("R2 lp sram read latency", c, 2);
        check("R2 lp sram read data", int'(d), int'(mem[7]));
        xfer(0, 0, REGB | AW'(3), '0, d, c);
        check("R3 lp reg read latency wait0", c, 2);
        xfer(1, 0, REGB | AW'(3), '0, d, c);
        check("R4 sp reg read latency wait0", c, 2);
        xfer(1, 1, REGB, 16'h0001, d, c);
        check("R4 sp reg write latency", c, 2);
    endtask

    task automatic t_reg_space();
        logic [DW-1:0] d; int c; int n0; logic [DW-1:0] m2;
        n0 = log_n; m2 = mem[2];
        xfer(0, 1, REGB | AW'(2), 16'h7777, d, c);
        check("R12 reg write starts no sram cycle", log_n, n0);
        check("R12 sram word untouched", int'(mem[2]), int'(m2));
        xfer(1, 0, REGB | AW'(2), '0, d, c);
        check("R12 reg readback", int'(d), 16'h7777);
    endtask

    task automatic t_prefetch();
        logic [DW-1:0] d; int c; int n0;
        n0 = log_n;
        xfer(1, 0, AW'(100), '0, d, c);
        check("R5 miss latency", c, 3);
        check("R5 miss data", int'(d), int'(mem[100]));
        idle(20);
        check("R5 sram access count", log_n - n0, 5);
        for (int i = 0; i < 5; i++) check("R5 fill order", log_a[n0 + i], 100 + i);
        n0 = log_n;
        xfer(1, 0, AW'(102), '0, d, c);
        check("R6 hit latency", c, 1);
        check("R6 hit data", int'(d), int'(mem[102]));
        xfer(1, 0, AW'(104), '0, d, c);
        check("R6 hit last word", int'(d), int'(mem[104]));
        check("R6 hits start no sram cycle", log_n, n0);
        // wrap at the top of SRAM space
        n0 = log_n;
        xfer(1, 0, AW'(SW - 2), '0, d, c);
        idle(20);
        check("R5 wrap fill address", log_a[n0 + 3], 1);
        xfer(1, 0, AW'(1), '0, d, c);
        check("R6 wrapped hit latency", c, 1);
    endtask

    task automatic t_invalidate();
        logic [DW-1:0] d; int c;
        xfer(1, 0, AW'(300), '0, d, c);
        idle(20);
        xfer(0, 1, AW'(302), 16'hA1A1, d, c);
        xfer(1, 0, AW'(302), '0, d, c);
        check("R7 lp write forces miss", c, 3);
        check("R7 lp write new data", int'(d), 16'hA1A1);
        idle(20);
        xfer(1, 1, AW'(304), 16'hC3C3, d, c);
        xfer(1, 0, AW'(304), '0, d, c);
        check("R7 sp write forces miss", c, 3);
        check("R7 sp write new data", int'(d), 16'hC3C3);
        idle(20);
    endtask

    task automatic t_arbitrate();
        int lc = 0, sc = 0, cyc = 0;
        @(negedge clk);
        lp_valid = 1; lp_write = 0; lp_addr = REGB | AW'(3);
        sp_valid = 1; sp_write = 0; sp_addr = REGB | AW'(2);
        while ((lc == 0 || sc == 0) && cyc < 100) begin
            @(posedge clk); #1;
            cyc++;
            if (lp_ready && lc == 0) lc = cyc;
            if (sp_ready && sc == 0) sc = cyc;
            @(negedge clk);
            if (lc != 0) lp_valid = 0;
            if (sc != 0) sp_valid = 0;
        end
        check("R8 local served with normal latency", lc, 3);
        check("R8 local before slave", int'(lc < sc), 1);
    endtask

    task automatic t_interrupt();
        logic [DW-1:0] d; int c; int pa, pb, pz;
        xfer(1, 0, AW'(200), '0, d, c);
        idle(4);
        xfer(0, 0, AW'(400), '0, d, c);
        check("R9 local data during fill", int'(d), int'(mem[400]));
        idle(20);
        pa = find_pos(201); pb = find_pos(400); pz = find_pos(204);
        check("R9 local after first fill word", int'(pb > pa && pa >= 0), 1);
        check("R9 local before last fill word", int'(pz > pb), 1);
        xfer(1, 0, AW'(204), '0, d, c);
        check("R9 fill completed after interruption", c, 1);
        check("R9 fill data", int'(d), int'(mem[204]));
    endtask

    initial begin
        for (int i = 0; i < SW; i++) mem[i] = DW'(16'h5000 + i);
        repeat (3) @(posedge clk);
        #1 rst = 0;
        idle(2);
        t_reset();
        t_wait_one();
        t_wait_zero();
        t_reg_space();
        t_prefetch();
        t_invalidate();
        t_arbitrate();
        t_interrupt();
        check("R10 ready pulse width violations", pulse_bad, 0);
        check("R11 strobe violations", strobe_bad, 0);
        check("R11 write strobe observed", int'(writes_seen > 0), 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule